// File: doc/BRIEF.md
# System Interrupt Mask and Routing Controller

This block is the shared, system-wide half of an interrupt controller. It watches 32 level-sensitive source lines. It records which sources are pending and keeps a disable mask whose top bit switches off all requests at once. It also holds the index of the processor that receives level updates. A fixed table gives each source a 4-bit priority level. Several sources can share one level, and a source whose level is zero does nothing at all.

Each edge on a source with a nonzero level produces a per-level set or clear pulse toward the per-processor pending registers. Each pulse is tagged with the target index. A rising source that passes the mask and the processor's priority check raises a one-cycle request strobe, which carries the level. Level 15 skips the priority check. Software reaches the pending register, the mask and the target index over a small word-addressed bus. Reads are combinational and writes take effect at the clock edge.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the disable mask reads 0xFFFFFFFF, the pending register reads 0, the target index reads 0, and no strobe or update pulse is active.
- R2: Reads return the pending register at word offset 0, the disable mask at offset 1 and the target index (zero-extended) at offset 4. Offsets 2, 3, 5, 6 and 7 read as zero.
- R3: A write to offset 2 updates the mask to `mask & ~(wdata | 32'h7FB2007F)`.
- R4: A write to offset 3 computes `d = wdata & ~32'h7FB2007F`. It ORs `d` into the mask and clears the bits of `d` from the pending register, even while those sources stay high.
- R5: A write to offset 4 stores `wdata[3:0]` as the target index.
- R6: The source-to-level map is: 0→2, 1→3, 2→5, 3→7, 4→9, 5→11, 7→14, 8→3, 9→5, 10→7, 11→9, 12→11, 13→13, 14→12, 15→12, 16→6, 18→4, 19→10, 20→8, 22→11, 28→15, and every other source →0. A level-0 source never sets its pending bit and never causes an update or a request.
- R7: A rising edge on a source with nonzero level L sets its pending bit and pulses `lvl_set_o[L]`. A falling edge clears the pending bit and pulses `lvl_clr_o[L]`. The pulse lasts one cycle, appears in the cycle after the edge is sampled, and carries `lvl_tgt_o` equal to the target index at that edge.
- R8: A rising source with level L raises the request only when its own mask bit and mask bit 31 are both clear. For L below 15 it also needs L > `cpu_pil_i` and `cpu_et_i` = 1.
- R9: A qualifying level-15 source raises the request whatever the values of `cpu_pil_i` and `cpu_et_i`.
- R10: `irq_req_o` is a one-cycle strobe in the cycle after the qualifying edge. `irq_level_o` carries the highest qualifying level among the sources that rose in that cycle.
- R11: Sources that change in the same cycle are taken in ascending bit order. When two sources of one level move in opposite directions, the higher-numbered source decides whether set or clear pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines, level-sensitive |
| bus_wr_i | input | 1 | Register write enable |
| bus_addr_i | input | 3 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| cpu_pil_i | input | 4 | Processor's current priority level |
| cpu_et_i | input | 1 | Processor trap enable |
| lvl_set_o | output | 16 | Per-level set pulse toward the per-processor registers |
| lvl_clr_o | output | 16 | Per-level clear pulse toward the per-processor registers |
| lvl_tgt_o | output | 4 | Target processor index for the update pulses |
| irq_req_o | output | 1 | Request strobe to the processor |
| irq_level_o | output | 4 | Level carried with the request strobe |

## Verification
The bench builds the block with its default parameters: 32 sources, a 3-bit word offset and a 4-bit target index. At this size it can sweep every source one at a time and compare the result against its own level table, and it can run every combination of processor priority and trap enable against a single mid-level source. Within reach are all eight read offsets, the effect of the reserved-bit pattern on both mask writes, and the same-cycle cases: several levels rising together, and two sources of one level moving in opposite directions.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NSRC       = 32;
  localparam int LVL_W      = 4;
  localparam int NLVL       = 1 << LVL_W;
  localparam int GLOBAL_BIT = NSRC - 1;
  localparam logic [NSRC-1:0] RSVD_BITS = 32'h7fb2007f;

  // Fixed priority level of each source; zero means unused.
  function automatic logic [LVL_W-1:0] src_level(input int idx);
    case (idx)
      0: return 4'd2;   1: return 4'd3;   2: return 4'd5;   3: return 4'd7;
      4: return 4'd9;   5: return 4'd11;  7: return 4'd14;  8: return 4'd3;
      9: return 4'd5;   10: return 4'd7;  11: return 4'd9;  12: return 4'd11;
      13: return 4'd13; 14: return 4'd12; 15: return 4'd12; 16: return 4'd6;
      18: return 4'd4;  19: return 4'd10; 20: return 4'd8;  22: return 4'd11;
      28: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  // Processor-side acceptance of a level; the top level bypasses the check.
  function automatic logic level_accepted(input logic [LVL_W-1:0] lv,
                                          input logic [LVL_W-1:0] pil,
                                          input logic et);
    return (lv == LVL_W'(NLVL - 1)) || ((lv > pil) && et);
  endfunction

  function automatic logic [NSRC-1:0] enable_apply(input logic [NSRC-1:0] mask,
                                                   input logic [NSRC-1:0] wd);
    return mask & ~(wd | RSVD_BITS);
  endfunction

  function automatic logic [NSRC-1:0] disable_bits(input logic [NSRC-1:0] wd);
    return wd & ~RSVD_BITS;
  endfunction
endpackage

// File: rtl/sirq_edge_track.sv
module sirq_edge_track
  import sirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pend_drop_i,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] fall_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] used;

  for (genvar g = 0; g < NSRC; g++) begin : g_used
    assign used[g] = (src_level(g) != '0);
  end

  assign rise_o = src_i & ~src_q & used;
  assign fall_o = ~src_i & src_q & used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= ((pend_o | rise_o) & ~fall_o) & ~pend_drop_i;
    end
  end

  p_unused_never_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & ~used) == '0);
  p_drop_clears_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_drop_i != '0) |=> ((pend_o & $past(pend_drop_i)) == '0));
endmodule

// File: rtl/sirq_cfg_regs.sv
module sirq_cfg_regs
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TGT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [NSRC-1:0]   pend_drop_o
);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_ENA  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_DIS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_TGT  = ADDR_W'(4);

  logic wr_ena, wr_dis, wr_tgt;
  assign wr_ena = wr_i && (addr_i == OFS_ENA);
  assign wr_dis = wr_i && (addr_i == OFS_DIS);
  assign wr_tgt = wr_i && (addr_i == OFS_TGT);

  assign pend_drop_o = wr_dis ? disable_bits(wdata_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      tgt_o  <= '0;
    end else begin
      if (wr_ena) mask_o <= enable_apply(mask_o, wdata_i);
      else if (wr_dis) mask_o <= mask_o | disable_bits(wdata_i);
      if (wr_tgt) tgt_o <= wdata_i[TGT_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      OFS_PEND: rdata_o = pend_i;
      OFS_MASK: rdata_o = mask_o;
      OFS_TGT:  rdata_o = NSRC'(tgt_o);
      default:  rdata_o = '0;
    endcase
  end

  p_enable_clears_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((mask_o & RSVD_BITS) == '0));
  p_disable_sets_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_o & $past(wdata_i & ~RSVD_BITS)) == $past(wdata_i & ~RSVD_BITS)));
  p_target_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt |=> (tgt_o == $past(wdata_i[TGT_W-1:0])));
endmodule

// File: rtl/sirq_qualify.sv
module sirq_qualify
  import sirq_pkg::*;
#(
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  rise_i,
  input  logic [NSRC-1:0]  fall_i,
  input  logic [NSRC-1:0]  mask_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [LVL_W-1:0] pil_i,
  input  logic             et_i,
  output logic [NLVL-1:0]  lvl_set_o,
  output logic [NLVL-1:0]  lvl_clr_o,
  output logic [TGT_W-1:0] lvl_tgt_o,
  output logic             irq_req_o,
  output logic [LVL_W-1:0] irq_level_o
);
  logic [NLVL-1:0]  set_n, clr_n;
  logic             hit_n;
  logic [LVL_W-1:0] best_n;

  // Ascending scan: a later (higher) source overrides an earlier one per level.
  always_comb begin
    logic [LVL_W-1:0] lv;
    set_n  = '0;
    clr_n  = '0;
    hit_n  = 1'b0;
    best_n = '0;
    for (int i = 0; i < NSRC; i++) begin
      lv = src_level(i);
      if (rise_i[i]) begin
        set_n[lv] = 1'b1;
        clr_n[lv] = 1'b0;
        if (!mask_i[i] && !mask_i[GLOBAL_BIT] && level_accepted(lv, pil_i, et_i)) begin
          hit_n = 1'b1;
          if (lv > best_n) best_n = lv;
        end
      end else if (fall_i[i]) begin
        set_n[lv] = 1'b0;
        clr_n[lv] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_set_o   <= '0;
      lvl_clr_o   <= '0;
      lvl_tgt_o   <= '0;
      irq_req_o   <= 1'b0;
      irq_level_o <= '0;
    end else begin
      lvl_set_o   <= set_n;
      lvl_clr_o   <= clr_n;
      lvl_tgt_o   <= tgt_i;
      irq_req_o   <= hit_n;
      irq_level_o <= hit_n ? best_n : '0;
    end
  end

  p_set_clr_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_set_o & lvl_clr_o) == '0);
  p_global_blocks_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> !$past(mask_i[GLOBAL_BIT]));
  p_top_level_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i[28] && !mask_i[28] && !mask_i[GLOBAL_BIT]) |=> (irq_req_o && irq_level_o == LVL_W'(NLVL - 1)));
  p_req_level_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_level_o != '0));
endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TGT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  input  logic [LVL_W-1:0]  cpu_pil_i,
  input  logic              cpu_et_i,
  output logic [NLVL-1:0]   lvl_set_o,
  output logic [NLVL-1:0]   lvl_clr_o,
  output logic [TGT_W-1:0]  lvl_tgt_o,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [NSRC-1:0]  rise, fall, pend, mask, pend_drop;
  logic [TGT_W-1:0] tgt;

  sirq_edge_track u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .pend_drop_i(pend_drop),
    .rise_o(rise), .fall_o(fall), .pend_o(pend)
  );

  sirq_cfg_regs #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .pend_i(pend), .rdata_o(bus_rdata_o),
    .mask_o(mask), .tgt_o(tgt), .pend_drop_o(pend_drop)
  );

  sirq_qualify #(.TGT_W(TGT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .mask_i(mask),
    .tgt_i(tgt), .pil_i(cpu_pil_i), .et_i(cpu_et_i),
    .lvl_set_o(lvl_set_o), .lvl_clr_o(lvl_clr_o), .lvl_tgt_o(lvl_tgt_o),
    .irq_req_o(irq_req_o), .irq_level_o(irq_level_o)
  );

  p_rise_sets_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0 && !bus_wr_i) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: tb/sys_irq_router_tb.sv
module sys_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RSV = 32'h7fb2007f;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pil = '0;
  logic        et = 1'b0;
  logic [15:0] lset, lclr;
  logic [3:0]  ltgt, rlvl;
  logic        req;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_pil_i(pil), .cpu_et_i(et),
    .lvl_set_o(lset), .lvl_clr_o(lclr), .lvl_tgt_o(ltgt),
    .irq_req_o(req), .irq_level_o(rlvl)
  );

  function automatic logic [3:0] lvl_of(input int i);
    case (i)
      0: return 2;  1, 8: return 3;  18: return 4;  2, 9: return 5;  16: return 6;
      3, 10: return 7;  20: return 8;  4, 11: return 9;  19: return 10;
      5, 12, 22: return 11;  14, 15: return 12;  13: return 13;  7: return 14;
      28: return 15;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] onehot(input logic [3:0] l);
    return (l == 0) ? 16'h0 : (16'h1 << l);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] a);
    return 32'h0;
  endfunction

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    read_chk("R1 mask", 3'd1, 32'hffffffff);
    read_chk("R1 pend", 3'd0, 32'h0);
    read_chk("R1 tgt", 3'd4, 32'h0);
    chk("R1 req", {31'h0, req}, 32'h0);
    chk("R1 lvl", {lset, lclr}, 32'h0);
    // R2 unmapped offsets
    for (int a = 2; a < 8; a++)
      if (a != 4) read_chk("R2 zero ofs", 3'(a), 32'h0);
    // R3 enable with zero data clears reserved bits only
    bus_write(3'd2, 32'h0);
    m = 32'hffffffff & ~RSV;
    read_chk("R3 enable rsvd", 3'd1, m);
    bus_write(3'd2, 32'h00000100);
    m = m & ~(32'h100 | RSV);
    read_chk("R3 enable bit", 3'd1, m);
    bus_write(3'd2, 32'hffffffff);
    read_chk("R3 enable all", 3'd1, 32'h0);
    // R4 disable respects reserved bits
    bus_write(3'd3, 32'hffffffff);
    read_chk("R4 disable all", 3'd1, ~RSV);
    bus_write(3'd2, 32'hffffffff);
    read_chk("R4 re-enable", 3'd1, 32'h0);
    // R5 target
    bus_write(3'd4, 32'h000000ab);
    read_chk("R5 target", 3'd4, 32'h0000000b);
    // R6/R7/R8/R10 sweep every source alone
    pil = 0; et = 1;
    for (int i = 0; i < 32; i++) begin
      logic [3:0] l;
      l = lvl_of(i);
      src[i] = 1'b1;
      step();
      read_chk("R6 R7 pend set", 3'd0, (l != 0) ? (32'h1 << i) : 32'h0);
      chk("R7 set pulse", {16'h0, lset}, {16'h0, onehot(l)});
      chk("R7 target", {28'h0, ltgt}, (l != 0) ? 32'hb : {28'h0, ltgt});
      chk("R8 R10 req", {31'h0, req}, {31'h0, l != 0});
      chk("R10 level", {28'h0, rlvl}, {28'h0, l});
      step();
      chk("R10 strobe one cycle", {31'h0, req}, 32'h0);
      src[i] = 1'b0;
      step();
      read_chk("R7 pend clr", 3'd0, 32'h0);
      chk("R7 clr pulse", {16'h0, lclr}, {16'h0, onehot(l)});
      chk("R7 no set on fall", {16'h0, lset}, 32'h0);
      step();
    end
    // R8 priority and trap-enable sweep on source 3 (level 7)
    for (int p = 0; p < 16; p++)
      for (int e = 0; e < 2; e++) begin
        pil = 4'(p); et = 1'(e);
        src[3] = 1'b1; step();
        chk("R8 pil/et", {31'h0, req}, {31'h0, (7 > p) && (e == 1)});
        src[3] = 1'b0; step(); step();
      end
    // R9 level 15 bypass
    pil = 4'd15; et = 1'b0;
    src[28] = 1'b1; step();
    chk("R9 bypass req", {31'h0, req}, 32'h1);
    chk("R9 bypass level", {28'h0, rlvl}, 32'd15);
    src[28] = 1'b0; step(); step();
    // R8 global disable blocks even level 15
    bus_write(3'd3, 32'h80000000);
    src[28] = 1'b1; step();
    chk("R8 global blocks", {31'h0, req}, 32'h0);
    read_chk("R8 global pend", 3'd0, 32'h10000000);
    src[28] = 1'b0; step();
    bus_write(3'd2, 32'h80000000);
    // R8 own mask bit blocks; R4 disable drops pending while high
    pil = 0; et = 1;
    bus_write(3'd3, 32'h00000080);
    src[7] = 1'b1; step();
    chk("R8 masked src", {31'h0, req}, 32'h0);
    read_chk("R8 masked pend", 3'd0, 32'h00000080);
    bus_write(3'd3, 32'h00000080);
    read_chk("R4 drop pend", 3'd0, 32'h0);
    step();
    read_chk("R4 stays dropped", 3'd0, 32'h0);
    src[7] = 1'b0; step();
    bus_write(3'd2, 32'h00000080);
    // R10 simultaneous rise picks highest level
    src = 32'h00000083; step();
    chk("R10 highest", {28'h0, rlvl}, 32'd14);
    chk("R10 req", {31'h0, req}, 32'h1);
    chk("R10 set vec", {16'h0, lset}, {16'h0, onehot(2) | onehot(3) | onehot(14)});
    src = 32'h0; step(); step();
    // R11 same-level opposite moves: higher bit decides
    src[1] = 1'b1; step(); step();
    src[1] = 1'b0; src[8] = 1'b1; step();
    chk("R11 high rises set", {16'h0, lset}, {16'h0, onehot(3)});
    chk("R11 high rises clr", {16'h0, lclr}, 32'h0);
    step();
    src[1] = 1'b1; src[8] = 1'b0; step();
    chk("R11 high falls clr", {16'h0, lclr}, {16'h0, onehot(3)});
    chk("R11 high falls set", {16'h0, lset}, 32'h0);
    src = 32'h0; step(); step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule